// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by reading a one-level page table kept in memory. A request carries the virtual address, the kind of access (read, write or instruction fetch) and the table base. The walker sends one word read to memory at the entry for the virtual page. It then decodes the returned entry and reports either the translated address or a fault.

Each entry is one 32-bit word. It holds a resident flag, three permission bits and the physical page number. The low twelve address bits form the page offset and pass through unchanged. A missing page and a forbidden access are reported as two distinct fault codes. Only one walk runs at a time. The block refuses new requests from acceptance until its result has been delivered.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, req_ready is 1 and mem_req_valid and res_valid are 0.
- R2: For an accepted request, exactly one memory read is issued, at address base + (vaddr[31:12] << 2). mem_req_valid and mem_req_addr hold steady until mem_req_ready is seen.
- R3: req_ready drops in the cycle after a request is accepted. It stays low through the cycle in which res_valid is high, and returns to 1 in the cycle after that.
- R4: If the entry's bit 31 (resident) is 1 and the access is allowed, res_fault is 0 and res_paddr is {entry[19:0], vaddr[11:0]}.
- R5: If entry bit 31 is 0, res_fault is 1 (page fault) whatever the permission bits hold. This fault wins over a protection fault.
- R6: Permission bits are entry bit 30 (read), bit 29 (write) and bit 28 (execute). req_acc 0 needs bit 30, 1 needs bit 29 and 2 needs bit 28. Code 3 is never allowed. A resident entry that lacks the needed bit gives res_fault 2 (protection violation).
- R7: res_valid is high for exactly one cycle per accepted request, and res_paddr is 0 whenever res_fault is not 0.
- R8: Entry bits 27..20 have no effect on the result.
- R9: The table base is sampled when the request is accepted. Later changes on req_base do not move the entry address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_base | input | 32 | Page table base address |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry word returned |
| mem_rsp_data | input | 32 | Entry word |
| res_valid | output | 1 | Result pulse |
| res_paddr | output | 32 | Translated physical address |
| res_fault | output | 2 | 0 none, 1 page fault, 2 protection violation |

## Verification
The two checks that can both hold on one entry are the residency test and the permission test. An entry that is not resident and also lacks the needed right triggers both in the same decode cycle. The bench provokes this with entries whose resident bit is clear and whose permission bits are all zero or mismatched. It expects fault code 1 every time, never 2. It also runs walks under a stalling memory and with changing unused entry bits and base values. Every result is compared against a scoreboard computed from the requirements.

// File: rtl/pt_pkg.sv
package pt_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PAGE = 2'd1,
        FLT_PROT = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        W_IDLE,
        W_ISSUE,
        W_WAIT,
        W_DONE
    } walk_st_e;

    localparam int PTE_RES_BIT = 31;
    localparam int PTE_RD_BIT  = 30;
    localparam int PTE_WR_BIT  = 29;
    localparam int PTE_EX_BIT  = 28;
endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
    parameter int VA_W  = 32,
    parameter int VPN_W = 20,
    parameter int SHIFT = 2
) (
    input  logic [VA_W-1:0]  base,
    input  logic [VPN_W-1:0] vpn,
    output logic [VA_W-1:0]  addr
);
    logic [VA_W-1:0] scaled;
    always_comb begin
        scaled = VA_W'(vpn) << SHIFT;
        addr   = base + scaled;
    end
endmodule

// File: rtl/pt_pte_check.sv
module pt_pte_check
    import pt_pkg::*;
#(
    parameter int PTE_W = 32,
    parameter int PPN_W = 20
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [1:0]       acc,
    output logic [1:0]       fault,
    output logic [PPN_W-1:0] ppn
);
    logic [3:0] allow;
    logic       resident;

    always_comb begin
        resident = pte[PTE_RES_BIT];
        allow    = {1'b0, pte[PTE_EX_BIT], pte[PTE_WR_BIT], pte[PTE_RD_BIT]};
        ppn      = pte[PPN_W-1:0];
        if (!resident)
            fault = FLT_PAGE;
        else if (!allow[acc])
            fault = FLT_PROT;
        else
            fault = FLT_NONE;
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PTE_W     = 32,
    parameter int PPN_W     = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic [VA_W-1:0]   req_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [VA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              res_valid,
    output logic [PPN_W+PAGE_BITS-1:0] res_paddr,
    output logic [1:0]        res_fault
);
    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int PA_W  = PPN_W + PAGE_BITS;
    localparam int SHIFT = $clog2(PTE_W / 8);

    typedef struct packed {
        walk_st_e              st;
        logic [PAGE_BITS-1:0]  off;
        logic [1:0]            acc;
        logic [VA_W-1:0]       ent;
        logic [PA_W-1:0]       paddr;
        logic [1:0]            fault;
    } regs_t;

    regs_t r_d, r_q;

    logic [VA_W-1:0]  ent_addr;
    logic [1:0]       chk_fault;
    logic [PPN_W-1:0] chk_ppn;

    pt_entry_addr #(.VA_W(VA_W), .VPN_W(VPN_W), .SHIFT(SHIFT)) u_addr (
        .base (req_base),
        .vpn  (req_vaddr[VA_W-1:PAGE_BITS]),
        .addr (ent_addr)
    );

    pt_pte_check #(.PTE_W(PTE_W), .PPN_W(PPN_W)) u_chk (
        .pte   (mem_rsp_data),
        .acc   (r_q.acc),
        .fault (chk_fault),
        .ppn   (chk_ppn)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            W_IDLE: if (req_valid) begin
                r_d.off = req_vaddr[PAGE_BITS-1:0];
                r_d.acc = req_acc;
                r_d.ent = ent_addr;
                r_d.st  = W_ISSUE;
            end
            W_ISSUE: if (mem_req_ready) r_d.st = W_WAIT;
            W_WAIT: if (mem_rsp_valid) begin
                r_d.fault = chk_fault;
                r_d.paddr = (chk_fault == FLT_NONE) ? {chk_ppn, r_q.off} : '0;
                r_d.st    = W_DONE;
            end
            W_DONE: r_d.st = W_IDLE;
            default: r_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: W_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign req_ready     = (r_q.st == W_IDLE);
    assign mem_req_valid = (r_q.st == W_ISSUE);
    assign mem_req_addr  = r_q.ent;
    assign res_valid     = (r_q.st == W_DONE);
    assign res_paddr     = r_q.paddr;
    assign res_fault     = r_q.fault;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        res_valid,
    input logic [31:0] res_paddr,
    input logic [1:0]  res_fault
);
    p_hold_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    p_single_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    p_ready_after_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> req_ready);

    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_fault_zero_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_fault != 2'd0 |-> res_paddr == 32'd0);

    p_fault_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_fault != 2'd3);
endmodule

bind pt_walker pt_walker_chk u_walker_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .res_valid     (res_valid),
    .res_paddr     (res_paddr),
    .res_fault     (res_fault)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic [31:0] req_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid;
    logic [31:0] res_paddr;
    logic [1:0]  res_fault;

    always #(CLK_P/2) clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_acc(req_acc), .req_base(req_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_paddr(res_paddr), .res_fault(res_fault)
    );

    typedef struct {
        logic [31:0] addr;
        logic [1:0]  fault;
        logic [31:0] paddr;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] mem [0:1023];
    int          n_run = 0;
    int          n_fail = 0;
    int          n_done = 0;
    int          n_reads = 0;
    bit          stall_mode = 1'b0;
    bit          pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int          stall_cnt = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_fault(input logic [31:0] pte, input logic [1:0] acc);
        logic ok;
        if (!pte[31]) return 2'd1;
        case (acc)
            2'd0: ok = pte[30];
            2'd1: ok = pte[29];
            2'd2: ok = pte[28];
            default: ok = 1'b0;
        endcase
        return ok ? 2'd0 : 2'd2;
    endfunction

    // memory model: ready pattern plus one-cycle response
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem[pend_addr[11:2]];
            pend = 1'b0;
        end
        stall_cnt++;
        mem_req_ready = stall_mode ? (stall_cnt % 4 == 3) : 1'b1;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            pend      = 1'b1;
            pend_addr = mem_req_addr;
            n_reads++;
            if (exp_q.size() > 0)
                check(mem_req_addr == exp_q[0].addr, {"R2 entry address ", exp_q[0].tag},
                      mem_req_addr, exp_q[0].addr);
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            exp_t e;
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected result", 32'd1, 32'd0);
            end else begin
                e = exp_q.pop_front();
                check(res_fault == e.fault, {"R4/R5/R6 fault ", e.tag}, 32'(res_fault), 32'(e.fault));
                check(res_paddr == e.paddr, {"R4/R7 paddr ", e.tag}, res_paddr, e.paddr);
                check(req_ready == 1'b0, "R3 busy during result", 32'(req_ready), 32'd0);
            end
            n_done++;
        end
    end

    task automatic walk(input logic [31:0] vaddr, input logic [1:0] acc,
                        input logic [31:0] base, input logic [31:0] pte, input string tag);
        exp_t e;
        int   target;
        int   reads0;
        logic [31:0] ea;
        ea = base + {vaddr[31:12], 2'b00};
        mem[ea[11:2]] = pte;
        e.addr  = ea;
        e.fault = exp_fault(pte, acc);
        e.paddr = (e.fault == 2'd0) ? {pte[19:0], vaddr[11:0]} : 32'd0;
        e.tag   = tag;
        exp_q.push_back(e);
        target = n_done + 1;
        reads0 = n_reads;
        @(negedge clk);
        check(req_ready == 1'b1, "R3 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_vaddr = vaddr; req_acc = acc; req_base = base;
        @(negedge clk);
        req_valid = 1'b0;
        req_base  = base ^ 32'h0000_0300;   // R9: base moves after acceptance
        req_vaddr = ~vaddr;
        check(req_ready == 1'b0, "R3 busy after accept", 32'(req_ready), 32'd0);
        wait (n_done == target);
        @(negedge clk);
        check(req_ready == 1'b1, "R3 ready after result", 32'(req_ready), 32'd1);
        check(res_valid == 1'b0, "R7 single pulse", 32'(res_valid), 32'd0);
        check(n_reads - reads0 == 1, "R2 one read per walk", 32'(n_reads - reads0), 32'd1);
    endtask

    initial begin
        #(CLK_P * 100000);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
        check(mem_req_valid == 1'b0, "R1 reset mem valid", 32'(mem_req_valid), 32'd0);
        check(res_valid == 1'b0, "R1 reset res valid", 32'(res_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && !mem_req_valid && !res_valid, "R1 after reset",
              {29'd0, req_ready, mem_req_valid, res_valid}, 32'd4);

        walk(32'h0000_5ABC, 2'd0, 32'h0000_0100, 32'hC00A_BCDE, "R4 read ok");
        walk(32'h0001_2345, 2'd1, 32'h0000_0200, 32'hA001_2345, "R4 write ok");
        walk(32'h0003_0FFF, 2'd2, 32'h0000_0040, 32'h9FFF_FFFF, "R4 exec ok");
        walk(32'h0000_7000, 2'd0, 32'h0000_0100, 32'h7000_0123, "R5 absent with rights");
        walk(32'h0000_8001, 2'd1, 32'h0000_0100, 32'h0000_0456, "R5 absent no rights");
        walk(32'h0000_9010, 2'd1, 32'h0000_0100, 32'hC000_0777, "R6 write on read-only");
        walk(32'h0000_A020, 2'd2, 32'h0000_0100, 32'hE000_0888, "R6 exec denied");
        walk(32'h0000_B030, 2'd0, 32'h0000_0100, 32'hB000_0999, "R6 read denied");
        walk(32'h0000_C040, 2'd3, 32'h0000_0100, 32'hF000_0AAA, "R6 reserved access");
        walk(32'h0000_D123, 2'd0, 32'h0000_0100, 32'hCFF1_2345, "R8 ignored bits set");
        walk(32'h0000_D123, 2'd0, 32'h0000_0100, 32'hC001_2345, "R8 ignored bits clear");
        stall_mode = 1'b1;
        walk(32'h0002_0F00, 2'd1, 32'h0000_0300, 32'hA00F_EDCB, "R2 stalled memory");
        walk(32'h0000_E004, 2'd0, 32'h0000_0080, 32'h0000_0000, "R5 stalled absent");
        walk(32'h0004_0321, 2'd2, 32'h0000_0000, 32'h9ABC_D000, "R9 base zero exec");
        stall_mode = 1'b0;
        walk(32'hFFFF_FFFF & 32'h000F_F0FF, 2'd0, 32'h0000_0000, 32'hC005_5555, "R4 high vpn");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R7 all results delivered", 32'(exp_q.size()), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule